// File: doc/BRIEF.md
# Script Conditional Branch Evaluator

This block resolves one flow-control instruction of a script-driven bus controller. A fetch unit hands it the command byte, the 24-bit operand field, a 32-bit target word and the current script pointer, together with a one-cycle `instr_valid` strobe. The block decides whether the branch is taken. It returns the next script pointer with a one-cycle `done` pulse.

The branch condition can combine a compare of the live bus phase lines against a phase coded in the command, and a masked compare of the live data byte against an operand constant. The sense of the branch can be set to act on a true condition or on a false one. The evaluator can also hold the decision until the bus raises its request handshake, and it samples phase and data in that cycle. A single return-address register supports one level of call and return. A taken interrupt instruction raises an interrupt that carries the target word as its vector, and it stops the evaluator until reset.

Top module: `tcb_eval`

## Requirements
- R1: The instruction is illegal unless `cmd[7:6]` is 2'b10 and `cmd[5]` is 0. An illegal instruction gives `done` with `illegal`=1, `taken`=0, `irq`=0 and `next_ptr` equal to `script_ptr`.
- R2: If any of `operand[23:20]` is nonzero, the instruction is illegal, with the same outputs as in R1.
- R3: The condition is the AND of the enabled compares. `operand[17]` enables the phase compare: `bus_phase` ({msg, c/d, i/o}) must equal `cmd[2:0]`. `operand[18]` enables the data compare: `bus_data` must equal `operand[7:0]` in every bit position where `operand[15:8]` is 0. With neither compare enabled, the condition is true.
- R4: If `operand[19]`=1, the branch is taken when the condition is true. If `operand[19]`=0, it is taken when the condition is false.
- R5: If `operand[16]`=1, the block stays `busy` and gives no `done` until a cycle in which `bus_req` is 1. Phase and data are sampled in that cycle, and `done` follows one cycle later.
- R6: Without a wait, `done` and its results appear in the cycle after the one in which `instr_valid` was sampled.
- R7: The operation is selected by `cmd[4:3]`: 00 jump, 01 call, 10 return, 11 interrupt. A taken jump gives `next_ptr` = `target`. Any legal instruction that is not taken gives `next_ptr` = `script_ptr` + 8.
- R8: A taken call gives `next_ptr` = `target` and stores `script_ptr` + 8 in the return register. A call that is not taken leaves the return register unchanged.
- R9: A taken return gives `next_ptr` equal to the return register. Reset clears the return register to 0.
- R10: A taken interrupt pulses `irq` together with `done` and presents `target` on `irq_vector`. It then sets `halted`. While `halted` is set, `instr_valid` is ignored until reset.
- R11: After reset, `done`, `taken`, `illegal`, `irq`, `busy` and `halted` are 0 and `next_ptr` is 0.
- R12: While `busy`, a new `instr_valid` is ignored and does not disturb the instruction that is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| cmd | input | 8 | Command byte |
| operand | input | 24 | Condition and compare operand |
| target | input | 32 | Branch target or interrupt vector |
| script_ptr | input | 32 | Address of the current instruction |
| bus_phase | input | 3 | Live phase lines {msg, c/d, i/o} |
| bus_data | input | 8 | Live data byte |
| bus_req | input | 1 | Request handshake valid |
| busy | output | 1 | Waiting for handshake |
| done | output | 1 | Result valid pulse |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Instruction rejected |
| next_ptr | output | 32 | Next script pointer |
| irq | output | 1 | Interrupt pulse |
| irq_vector | output | 32 | Vector of last interrupt |
| halted | output | 1 | Stopped after interrupt |

## Verification
The bench targets masked data bits, a phase mismatch on a single line, and both compares enabled under the false sense. A design that inverted the mask would take the masked vectors the wrong way. A design that evaluated at acceptance instead of at the handshake would branch on stale phase lines in the wait test. The bench also issues a call that is not taken and then a return. A design that saved the return address without checking `taken` would return to the wrong address. Illegal commands, strobes during a wait and strobes after an interrupt must leave the pointer and the return register untouched.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int CMD_W   = 8;
  localparam int OPR_W   = 24;
  localparam int DATA_W  = 8;
  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {OP_JUMP = 2'd0, OP_CALL = 2'd1, OP_RETURN = 2'd2, OP_INT = 2'd3} tc_op_e;

  typedef struct packed {
    logic               type_ok;
    logic               rsvd_ok;
    logic               op_ok;
    tc_op_e             op;
    logic [PHASE_W-1:0] exp_phase;
    logic               on_true;
    logic               data_en;
    logic               phase_en;
    logic               wait_req;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  cdata;
  } tc_fields_t;

  // a set mask bit removes that bit position from the compare
  function automatic logic masked_match(input logic [DATA_W-1:0] d,
                                        input logic [DATA_W-1:0] c,
                                        input logic [DATA_W-1:0] m);
    return ((d ^ c) & ~m) == '0;
  endfunction
endpackage

// File: rtl/tcb_decode.sv
module tcb_decode
  import tcb_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [OPR_W-1:0] opr,
  output tc_fields_t       f
);
  always_comb begin
    f.type_ok   = (cmd[7:6] == 2'b10);
    f.op_ok     = ~cmd[5];
    f.op        = tc_op_e'(cmd[4:3]);
    f.exp_phase = cmd[2:0];
    f.rsvd_ok   = (opr[23:20] == 4'd0);
    f.on_true   = opr[19];
    f.data_en   = opr[18];
    f.phase_en  = opr[17];
    f.wait_req  = opr[16];
    f.mask      = opr[15:8];
    f.cdata     = opr[7:0];
  end
endmodule

// File: rtl/tcb_cond.sv
module tcb_cond
  import tcb_pkg::*;
(
  input  tc_fields_t         f,
  input  logic [PHASE_W-1:0] phase,
  input  logic [DATA_W-1:0]  data,
  output logic               cond_true,
  output logic               take
);
  logic phase_ok, data_ok;
  always_comb begin
    phase_ok  = ~f.phase_en | (phase == f.exp_phase);
    data_ok   = ~f.data_en  | masked_match(data, f.cdata, f.mask);
    cond_true = phase_ok & data_ok;
    take      = (cond_true == f.on_true);
  end
endmodule

// File: rtl/tcb_ptr.sv
module tcb_ptr
  import tcb_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int STEP  = 8
) (
  input  tc_op_e           op,
  input  logic             take,
  input  logic             legal,
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] target,
  input  logic [PTR_W-1:0] ret_addr,
  output logic [PTR_W-1:0] seq_ptr,
  output logic [PTR_W-1:0] next_ptr,
  output logic             save_ret,
  output logic             raise_irq
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
  logic go;
  always_comb begin
    seq_ptr   = cur_ptr + STEP_V;
    go        = legal & take;
    save_ret  = go & (op == OP_CALL);
    raise_irq = go & (op == OP_INT);
    if (!legal)          next_ptr = cur_ptr;
    else if (!take)      next_ptr = seq_ptr;
    else begin
      unique case (op)
        OP_JUMP, OP_CALL: next_ptr = target;
        OP_RETURN:        next_ptr = ret_addr;
        default:          next_ptr = seq_ptr;
      endcase
    end
  end
endmodule

// File: rtl/tcb_eval.sv
module tcb_eval
  import tcb_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int STEP  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [OPR_W-1:0]   operand,
  input  logic [PTR_W-1:0]   target,
  input  logic [PTR_W-1:0]   script_ptr,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               bus_req,
  output logic               busy,
  output logic               done,
  output logic               taken,
  output logic               illegal,
  output logic [PTR_W-1:0]   next_ptr,
  output logic               irq,
  output logic [PTR_W-1:0]   irq_vector,
  output logic               halted
);
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;
  st_e state_q;

  logic [CMD_W-1:0] cmd_q;
  logic [OPR_W-1:0] opr_q;
  logic [PTR_W-1:0] tgt_q, ptr_q, ret_q;
  logic [CMD_W-1:0] cmd_s;
  logic [OPR_W-1:0] opr_s;
  logic [PTR_W-1:0] tgt_s, ptr_s;

  tc_fields_t f;
  logic accept, use_held, illegal_w, go_wait, fire;
  logic cond_w, take_w, save_ret, raise_irq;
  logic [PTR_W-1:0] seq_w, next_w;

  assign accept   = instr_valid & (state_q == ST_IDLE) & ~halted;
  assign use_held = (state_q == ST_WAIT);
  assign cmd_s    = use_held ? cmd_q : cmd;
  assign opr_s    = use_held ? opr_q : operand;
  assign tgt_s    = use_held ? tgt_q : target;
  assign ptr_s    = use_held ? ptr_q : script_ptr;

  tcb_decode u_dec (.cmd(cmd_s), .opr(opr_s), .f(f));

  assign illegal_w = ~(f.type_ok & f.rsvd_ok & f.op_ok);
  assign go_wait   = accept & ~illegal_w & f.wait_req;
  assign fire      = (accept & ~go_wait) | (use_held & bus_req);

  tcb_cond u_cond (.f(f), .phase(bus_phase), .data(bus_data),
                   .cond_true(cond_w), .take(take_w));

  tcb_ptr #(.PTR_W(PTR_W), .STEP(STEP)) u_ptr (
    .op(f.op), .take(take_w), .legal(~illegal_w), .cur_ptr(ptr_s),
    .target(tgt_s), .ret_addr(ret_q), .seq_ptr(seq_w), .next_ptr(next_w),
    .save_ret(save_ret), .raise_irq(raise_irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      opr_q      <= '0;
      tgt_q      <= '0;
      ptr_q      <= '0;
      ret_q      <= '0;
      done       <= 1'b0;
      taken      <= 1'b0;
      illegal    <= 1'b0;
      next_ptr   <= '0;
      irq        <= 1'b0;
      irq_vector <= '0;
      halted     <= 1'b0;
    end else begin
      done <= fire;
      irq  <= fire & raise_irq;
      if (accept) begin
        cmd_q <= cmd;
        opr_q <= operand;
        tgt_q <= target;
        ptr_q <= script_ptr;
      end
      if (go_wait)                  state_q <= ST_WAIT;
      else if (use_held && bus_req) state_q <= ST_IDLE;
      if (fire) begin
        taken    <= take_w & ~illegal_w;
        illegal  <= illegal_w;
        next_ptr <= next_w;
        if (save_ret) ret_q <= seq_w;
        if (raise_irq) begin
          irq_vector <= tgt_s;
          halted     <= 1'b1;
        end
      end
    end
  end

  assign busy = (state_q == ST_WAIT);

  logic unused_cond;
  assign unused_cond = cond_w;
endmodule

// File: rtl/tcb_eval_chk.sv
module tcb_eval_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic bus_req,
  input logic done,
  input logic taken,
  input logic illegal,
  input logic irq,
  input logic halted
);
  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!taken && !irq));                        // R1
  AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req) |=> !done);                                  // R5
  AST_IRQ_WITH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && taken && halted));                             // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);                                             // R10
  AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !done);                                              // R10
  AST_HANDSHAKE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_req) |=> (done && !busy));                         // R5
endmodule

bind tcb_eval tcb_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_req(bus_req), .done(done),
  .taken(taken), .illegal(illegal), .irq(irq), .halted(halted));

// File: tb/tcb_eval_tb.sv
module tcb_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [7:0]  cmd = '0;
  logic [23:0] operand = '0;
  logic [31:0] target = '0, script_ptr = '0;
  logic [2:0]  bus_phase = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_req = 1'b0;
  logic        busy, done, taken, illegal, irq, halted;
  logic [31:0] next_ptr, irq_vector;

  int n_run = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;

  tcb_eval dut_i (.*);

  // {cmd, operand, phase, data, expected taken}; all jumps
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {8'h80, 24'h080000, 3'b000, 8'h00, 1'b1},
    {8'h80, 24'h000000, 3'b000, 8'h00, 1'b0},
    {8'h82, 24'h0A0000, 3'b010, 8'h00, 1'b1},
    {8'h82, 24'h0A0000, 3'b011, 8'h00, 1'b0},
    {8'h80, 24'h0C00A5, 3'b000, 8'hA5, 1'b1},
    {8'h80, 24'h0C00A5, 3'b000, 8'hA4, 1'b0},
    {8'h80, 24'h0C0FA5, 3'b000, 8'hA0, 1'b1},
    {8'h80, 24'h0C0FA5, 3'b000, 8'hB5, 1'b0},
    {8'h82, 24'h0600A5, 3'b010, 8'h00, 1'b1},
    {8'h82, 24'h0600A5, 3'b010, 8'hA5, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one instruction for one cycle; results observed at the following negedge
  task automatic issue(input logic [7:0] c, input logic [23:0] o, input logic [31:0] t,
                       input logic [31:0] p, input logic [2:0] ph, input logic [7:0] d,
                       input logic rq);
    @(negedge clk);
    cmd = c; operand = o; target = t; script_ptr = p;
    bus_phase = ph; bus_data = d; bus_req = rq; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_p;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", {31'd0, done}, 32'd0);
    check("R11 busy/irq/halted", {29'd0, busy, irq, halted}, 32'd0);
    check("R11 next_ptr", next_ptr, 32'd0);
    rst_n = 1'b1;

    // R9 return before any call yields reset value 0
    issue(8'h90, 24'h080000, 32'h1111, 32'h400, 3'b0, 8'h0, 1'b0);
    check("R9 return after reset", next_ptr, 32'h0);

    // R3 R4 R7 vector table, R6 one-cycle latency
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][43:36], VEC[i][35:12], 32'h2000_0040, 32'h1000, VEC[i][11:9], VEC[i][8:1], 1'b0);
      check($sformatf("R6 done vec%0d", i), {31'd0, done}, 32'd1);
      check($sformatf("R3/R4 taken vec%0d", i), {31'd0, taken}, {31'd0, VEC[i][0]});
      exp_p = VEC[i][0] ? 32'h2000_0040 : 32'h1008;
      check($sformatf("R7 next vec%0d", i), next_ptr, exp_p);
    end

    // R1 bad type, bad op
    issue(8'h40, 24'h080000, 32'h2000, 32'h1234, 3'b0, 8'h0, 1'b0);
    check("R1 illegal type", {30'd0, illegal, taken}, 32'd2);
    check("R1 ptr held", next_ptr, 32'h1234);
    issue(8'hA0, 24'h080000, 32'h2000, 32'h1238, 3'b0, 8'h0, 1'b0);
    check("R1 illegal op", {30'd0, done, illegal}, 32'd3);
    // R2 reserved bits
    issue(8'h80, 24'h180000, 32'h2000, 32'h1240, 3'b0, 8'h0, 1'b0);
    check("R2 reserved", {29'd0, illegal, taken, irq}, 32'd4);
    check("R2 ptr held", next_ptr, 32'h1240);

    // R5 R12 wait for handshake
    issue(8'h82, 24'h0B0000, 32'h7000, 32'h600, 3'b000, 8'h0, 1'b0);
    check("R5 busy", {30'd0, busy, done}, 32'd2);
    cmd = 8'h40; operand = 24'h0; script_ptr = 32'h999; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R12 ignored while busy", {30'd0, busy, done}, 32'd2);
    bus_phase = 3'b010; bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    check("R5 done after req", {30'd0, done, taken}, 32'd3);
    check("R5 next", next_ptr, 32'h7000);
    check("R5 idle", {31'd0, busy}, 32'd0);

    // R8 call / R9 return
    issue(8'h88, 24'h080000, 32'h5000, 32'h300, 3'b0, 8'h0, 1'b0);
    check("R8 call next", next_ptr, 32'h5000);
    issue(8'h88, 24'h000000, 32'h6000, 32'h700, 3'b0, 8'h0, 1'b0);
    check("R8 untaken call", next_ptr, 32'h708);
    issue(8'h90, 24'h080000, 32'h0, 32'h5008, 3'b0, 8'h0, 1'b0);
    check("R9 return", next_ptr, 32'h308);

    // R10 untaken int, then taken int
    issue(8'h98, 24'h000000, 32'hBAD0, 32'h800, 3'b0, 8'h0, 1'b0);
    check("R10 untaken int", {30'd0, irq, halted}, 32'd0);
    check("R10 untaken next", next_ptr, 32'h808);
    issue(8'h98, 24'h080000, 32'hDEADBEEF, 32'h900, 3'b0, 8'h0, 1'b0);
    check("R10 irq", {29'd0, irq, done, halted}, 32'd7);
    check("R10 vector", irq_vector, 32'hDEADBEEF);
    issue(8'h80, 24'h080000, 32'h4444, 32'hA00, 3'b0, 8'h0, 1'b0);
    check("R10 halted ignores", {30'd0, done, halted}, 32'd1);
    check("R10 ptr kept", next_ptr, 32'h908);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule